// File: doc/BRIEF.md
# Programmable Multi-Line Edge Detector

This block watches a wide bus of single-bit signal lines (256 by default) and reports, every clock, which lines showed a transition of interest. Software picks, line by line, whether a rising transition, a falling transition or either one counts. Software can also silence any line with a per-line mask bit. A global enable gates the whole detector. The result is a registered per-line event vector and a single registered flag that is high whenever any bit of that vector is high.

Configuration lives in 32-bit registers behind a plain write-strobe and address port, with the read data decoded combinationally from the address. The edge-type fields are 2 bits wide and packed sixteen to a word. The mask bits are packed thirty-two to a word. Software computes word and bit positions from the line number, so the register offsets and field packing are fixed.

Top module: `mled_top`

## Requirements
- R1: After a cycle with `rst_n` low, `events` and `any_edge` are zero, every edge-type word reads 0, every mask word reads 0xFFFFFFFF and the control word reads 0.
- R2: A line whose edge-type code is 2'b00 reports an event only when its sampled value goes from 0 to 1.
- R3: A line whose edge-type code is 2'b01 reports an event only when its sampled value goes from 1 to 0.
- R4: A line whose edge-type code is 2'b10 reports an event on every change of its sampled value.
- R5: A line whose edge-type code is 2'b11 never reports an event.
- R6: Mask word n sits at byte offset 0x848+4*n, and line i is masked by bit i%32 of word i/32. A mask bit of 1 keeps that line's event low, and a mask bit of 0 lets it through.
- R7: Edge-type word n sits at byte offset 0x808+4*n, and line i uses bits [2*(i%16)+1:2*(i%16)] of word i/16.
- R8: Bit 0 of the control word at offset 0x780 is the enable. While it is 0, `events` stays zero, but the line history keeps updating, so enabling while the lines are steady yields no event.
- R9: A line value applied before clock edge k is sampled at edge k, and the resulting event is visible after edge k+1. It lasts one cycle if the line then holds steady.
- R10: `any_edge` is high in exactly the cycles in which `events` is non-zero.
- R11: `reg_rdata` returns the stored word for a mapped offset. It returns the enable in bit 0 (other bits zero) for the control word, and zero for any unmapped or unaligned offset.
- R12: A write is applied at the clock edge that samples it. The event produced at that same edge still uses the configuration held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| lines_in | input | NUM_LINES | Monitored lines |
| events | output | NUM_LINES | Registered per-line event vector |
| any_edge | output | 1 | Registered OR of `events` |

## Verification
Two functions can meet in one cycle: a configuration write (mask, edge type or enable) and the event-register update for a transition that is already sampled. The bench provokes this by toggling lines at one falling edge and, at the next, writing a mask or edge-type word that would change the outcome. Its scoreboard model computes each cycle's expected vector from the configuration held before that edge and only then applies the write, so an event must appear or disappear one cycle after the write, not at it.

// File: rtl/mled_pkg.sv
// Package: shared offsets, edge-type codes and the per-line detect function.
// Assumes 12-bit byte addresses and 32-bit register words.
package mled_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned CTRL_OFS = 'h780;
    localparam int unsigned EDGE_OFS = 'h808;
    localparam int unsigned MASK_OFS = 'h848;

    typedef enum logic [1:0] {
        KIND_RISE = 2'b00,
        KIND_FALL = 2'b01,
        KIND_BOTH = 2'b10,
        KIND_NONE = 2'b11
    } edge_kind_e;

    // Return 1 when the transition prev->cur matches the selected kind.
    function automatic logic kind_hit(input logic [1:0] kind, input logic cur, input logic prev);
        case (edge_kind_e'(kind))
            KIND_RISE: kind_hit = cur & ~prev;
            KIND_FALL: kind_hit = ~cur & prev;
            KIND_BOTH: kind_hit = cur ^ prev;
            default:   kind_hit = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/mled_regs.sv
// Configuration registers: control word, edge-type words and mask words.
// Assumes NUM_LINES is a multiple of 32. Writes land at the sampling edge;
// read data is decoded combinationally, unmapped offsets read zero.
module mled_regs
    import mled_pkg::*;
#(
    parameter int unsigned NUM_LINES = 256,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [WORD_W-1:0]      reg_wdata,
    output logic [WORD_W-1:0]      reg_rdata,
    output logic                   enable,
    output logic [2*NUM_LINES-1:0] edge_cfg,
    output logic [NUM_LINES-1:0]   mask_cfg
);
    localparam int unsigned EDGE_REGS = NUM_LINES / 16;
    localparam int unsigned MASK_REGS = NUM_LINES / 32;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

    logic [WORD_W-1:0] edge_q [EDGE_REGS];
    logic [WORD_W-1:0] mask_q [MASK_REGS];
    logic              en_q;

    // Control word: enable flag in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                          en_q <= 1'b0;
        else if (reg_we && reg_addr == CTRL_A) en_q <= reg_wdata[0];
    end

    for (genvar g = 0; g < EDGE_REGS; g++) begin : g_edge
        localparam logic [ADDR_W-1:0] A = ADDR_W'(EDGE_OFS + 4 * g);
        // Edge-type word g: clears to all-rising on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                     edge_q[g] <= '0;
            else if (reg_we && reg_addr == A) edge_q[g] <= reg_wdata;
        end
        assign edge_cfg[g*WORD_W +: WORD_W] = edge_q[g];
    end

    for (genvar g = 0; g < MASK_REGS; g++) begin : g_mask
        localparam logic [ADDR_W-1:0] A = ADDR_W'(MASK_OFS + 4 * g);
        // Mask word g: sets to all-masked on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                     mask_q[g] <= '1;
            else if (reg_we && reg_addr == A) mask_q[g] <= reg_wdata;
        end
        assign mask_cfg[g*WORD_W +: WORD_W] = mask_q[g];
    end

    // Read decode: one match at most, zero otherwise.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_A) reg_rdata = {{(WORD_W-1){1'b0}}, en_q};
        for (int i = 0; i < EDGE_REGS; i++)
            if (reg_addr == ADDR_W'(EDGE_OFS + 4 * i)) reg_rdata = edge_q[i];
        for (int i = 0; i < MASK_REGS; i++)
            if (reg_addr == ADDR_W'(MASK_OFS + 4 * i)) reg_rdata = mask_q[i];
    end

    assign enable = en_q;

    // R12: a control write shows up on the enable one cycle later.
    a_r12_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == CTRL_A) |=> (enable == $past(reg_wdata[0])));

    // R12: with no write, the enable holds.
    a_r12_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == CTRL_A) |=> $stable(enable));
endmodule

// File: rtl/mled_edge_bank.sv
// Edge bank: samples the lines, keeps one cycle of history, applies
// per-line kind and mask, and registers the events and their OR.
// Assumes configuration inputs are register outputs (stable within a cycle).
module mled_edge_bank
    import mled_pkg::*;
#(
    parameter int unsigned NUM_LINES = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   lines_in,
    input  logic                   enable,
    input  logic [2*NUM_LINES-1:0] edge_cfg,
    input  logic [NUM_LINES-1:0]   mask_cfg,
    output logic [NUM_LINES-1:0]   events,
    output logic                   any_edge
);
    logic [NUM_LINES-1:0] cur_q, prev_q, hit, pass;

    // Sample and history registers; they run regardless of enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            cur_q  <= lines_in;
            prev_q <= cur_q;
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign hit[i] = kind_hit(edge_cfg[2*i +: 2], cur_q[i], prev_q[i]);

        // R6: a masked line shows no event at the next edge.
        a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            mask_cfg[i] |=> !events[i]);

        // R5: the reserved kind never reports.
        a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_cfg[2*i +: 2] == 2'b11) |=> !events[i]);

        // R2: an unmasked rising transition on a rise line must report.
        a_r2_rise_reports: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && !mask_cfg[i] && edge_cfg[2*i +: 2] == 2'b00 && cur_q[i] && !prev_q[i])
            |=> events[i]);
    end

    assign pass = hit & ~mask_cfg;

    // Event register: gated by the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            events   <= '0;
            any_edge <= 1'b0;
        end else begin
            events   <= enable ? pass : '0;
            any_edge <= enable & (|pass);
        end
    end

    // R8: disabled means an all-zero event vector next cycle.
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (events == '0));

    // R9: events reflect only history already sampled: steady lines give nothing.
    a_r9_steady_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == prev_q) |=> (events == '0));
endmodule

// File: rtl/mled_top.sv
// Top: programmable multi-line edge detector. Joins the register file
// and the edge bank. Assumes NUM_LINES is a multiple of 32, at most 256.
module mled_top
    import mled_pkg::*;
#(
    parameter int unsigned NUM_LINES = 256,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic [NUM_LINES-1:0] events,
    output logic                 any_edge
);
    logic                   enable;
    logic [2*NUM_LINES-1:0] edge_cfg;
    logic [NUM_LINES-1:0]   mask_cfg;

    mled_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .enable(enable),
        .edge_cfg(edge_cfg), .mask_cfg(mask_cfg)
    );

    mled_edge_bank #(.NUM_LINES(NUM_LINES)) bank_i (
        .clk(clk), .rst_n(rst_n), .lines_in(lines_in), .enable(enable),
        .edge_cfg(edge_cfg), .mask_cfg(mask_cfg), .events(events), .any_edge(any_edge)
    );

    // R10: the flag and the vector agree in every cycle.
    a_r10_any_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        any_edge == (events != '0));
endmodule

// File: tb/mled_top_tb_top.sv
// Scoreboard bench: a model process pushes the expected event vector each
// edge, and a monitor pops it half a cycle later and compares.
module mled_top_tb_top;
    localparam int N = 256;
    localparam int NE = N / 16;
    localparam int NM = N / 32;

    logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [N-1:0] lines_in = '0, events;
    logic any_edge;

    int n_chk = 0, n_fail = 0;
    string phase_req = "R1";
    logic [N-1:0] expq[$];
    bit done = 0;

    always #4 clk = ~clk;

    mled_top dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lines_in(lines_in),
        .events(events), .any_edge(any_edge));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Model: the expected vector uses pre-edge config, then the write applies.
    logic [31:0] m_edge [NE];
    logic [31:0] m_mask [NM];
    logic m_en;
    logic [N-1:0] m_cur, m_prev;
    always @(posedge clk) begin
        logic [N-1:0] e;
        logic [1:0] k;
        logic h;
        e = '0;
        if (!rst_n) begin
            m_en = 0; m_cur = '0; m_prev = '0;
            for (int i = 0; i < NE; i++) m_edge[i] = '0;
            for (int i = 0; i < NM; i++) m_mask[i] = '1;
        end else begin
            for (int i = 0; i < N; i++) begin
                k = m_edge[i/16][2*(i%16) +: 2];
                h = (k == 2'b00) ? (m_cur[i] & ~m_prev[i]) :
                    (k == 2'b01) ? (~m_cur[i] & m_prev[i]) :
                    (k == 2'b10) ? (m_cur[i] ^ m_prev[i]) : 1'b0;
                e[i] = m_en & ~m_mask[i/32][i%32] & h;
            end
            m_prev = m_cur;
            m_cur = lines_in;
            if (reg_we) begin
                if (reg_addr == 12'h780) m_en = reg_wdata[0];
                for (int i = 0; i < NE; i++) if (reg_addr == 12'h808 + 12'(4*i)) m_edge[i] = reg_wdata;
                for (int i = 0; i < NM; i++) if (reg_addr == 12'h848 + 12'(4*i)) m_mask[i] = reg_wdata;
            end
        end
        expq.push_back(e);
    end

    // Monitor: compare at the falling edge, away from the update edge.
    always @(negedge clk) begin
        logic [N-1:0] e;
        if (expq.size() > 0 && !done) begin
            e = expq.pop_front();
            chk(events === e, phase_req, "events", events, e);
            chk(any_edge === (|e), "R10", "any_edge", N'(any_edge), N'(|e));
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); reg_addr = a; #1;
        chk(reg_rdata === exp, req, "read", N'(reg_rdata), N'(exp));
    endtask

    task automatic fill_edge(input logic [31:0] d);
        for (int i = 0; i < NE; i++) wr(12'h808 + 12'(4*i), d);
    endtask

    task automatic fill_mask(input logic [31:0] d);
        for (int i = 0; i < NM; i++) wr(12'h848 + 12'(4*i), d);
    endtask

    task automatic rand_lines(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            lines_in = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired in phase %s", phase_req);
        finish_run();
    end

    initial begin
        lines_in = '1;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset values of all register kinds
        rd(12'h808, 32'h0, "R1");
        rd(12'h844, 32'h0, "R1");
        rd(12'h848, 32'hFFFF_FFFF, "R1");
        rd(12'h780, 32'h0, "R1");
        // R11: read-back, control bit 0 only, unmapped and unaligned zero
        phase_req = "R11";
        wr(12'h780, 32'hFFFF_FFFE);
        rd(12'h780, 32'h0, "R11");
        wr(12'h80C, 32'h1234_5678);
        rd(12'h80C, 32'h1234_5678, "R11");
        rd(12'h000, 32'h0, "R11");
        rd(12'h804, 32'h0, "R11");
        rd(12'h868, 32'h0, "R11");
        rd(12'h80D, 32'h0, "R11");
        wr(12'h80C, 32'h0);
        // R8: unmasked but disabled; then enable on steady lines
        phase_req = "R8";
        fill_mask(32'h0);
        rand_lines(20);
        wr(12'h780, 32'h1);
        rd(12'h780, 32'h1, "R8");
        repeat (4) @(negedge clk);
        phase_req = "R2";
        rand_lines(30);
        phase_req = "R3";
        fill_edge(32'h5555_5555);
        rand_lines(30);
        phase_req = "R4";
        fill_edge(32'hAAAA_AAAA);
        rand_lines(30);
        phase_req = "R5";
        fill_edge(32'hFFFF_FFFF);
        rand_lines(30);
        // R7: codes 00,01,10,11 rotate line by line inside each word
        phase_req = "R7";
        fill_edge(32'hE4E4_E4E4);
        wr(12'h820, 32'h1B1B_1B1B);
        rand_lines(40);
        // R6: mixed mask words
        phase_req = "R6";
        fill_edge(32'hAAAA_AAAA);
        fill_mask(32'hF0F0_A5A5);
        wr(12'h84C, 32'hFFFF_FFFF);
        rand_lines(30);
        // R9: single line 37 toggles, event one edge after sampling
        phase_req = "R9";
        fill_mask(32'h0);
        @(negedge clk); lines_in = '0;
        repeat (3) @(negedge clk);
        lines_in[37] = 1'b1;
        @(negedge clk);
        chk(events === '0, "R9", "not yet", events, '0);
        @(negedge clk);
        chk(events[37] === 1'b1, "R9", "line 37 event", events, N'(1) << 37);
        @(negedge clk);
        chk(events === '0, "R9", "one-cycle pulse", events, '0);
        // R12: toggle, then write mask=1 at the edge that registers the event
        phase_req = "R12";
        @(negedge clk); lines_in[37] = 1'b0;
        @(negedge clk); reg_we = 1; reg_addr = 12'h84C; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk); reg_we = 0;
        chk(events[37] === 1'b1, "R12", "old mask used", events, N'(1) << 37);
        @(negedge clk); lines_in[37] = 1'b1;
        repeat (2) @(negedge clk);
        chk(events[37] === 1'b0, "R12", "new mask used", events, '0);
        // R12: disable written in the cycle an event lands
        @(negedge clk); lines_in[3] = ~lines_in[3];
        @(negedge clk); reg_we = 1; reg_addr = 12'h780; reg_wdata = 32'h0;
        @(negedge clk); reg_we = 0;
        chk(events[3] === 1'b1, "R12", "old enable used", events, N'(1) << 3);
        rand_lines(10);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule